// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the device side of a host-driven serial link built from three wires: a serial clock that only the host generates, a single data line shared by both directions, and an active-low select. Through it a host reads and writes a bank of 8-bit registers held outside the block, each at a 7-bit address. The block never starts a transfer. It decodes the transfer direction from the top bit of the first byte and shifts in the address. It then either collects a data byte and issues a write strobe to the bank, or fetches the addressed register and shifts it out on the data line.

All three wires are brought into the fast system clock through flop synchronisers, and serial clock edges are found from the synchronised copy. The serial clock must run at no more than a quarter of the system clock rate. Raising select resets the port at any point in a transfer. Reading one dedicated address starts a burst. The port then streams a fixed, repeating list of registers until select is raised. The data line itself lives at the pad. The block supplies the output value and an output enable.

Top module: `serial_reg_port`

## Requirements
- R1: While select is high, the output enable stays low and serial clock and data activity are ignored: no write strobe is produced and no register changes.
- R2: A frame whose first byte carries a 1 in bit 7 is a write. Bits 6..0 of that byte are the address, MSB first, and the second byte is the data, MSB first. Both are sampled on serial clock rising edges. After the sixteenth rising edge, the port gives exactly one write strobe carrying that address and data.
- R3: A first byte with bit 7 equal to 0 is a read. Starting at the first falling edge after the eighth rising edge, the port drives the addressed register MSB first and changes the data only after falling edges, so the host can sample on rising edges.
- R4: Raising select before a write frame is complete discards the frame with no strobe. Raising select during a read stops the read. The next frame after such an abort is decoded normally.
- R5: Writes to read-only addresses produce no strobe. By default, addresses 0x00 to 0x07 are read-only.
- R6: Reading the burst address (default 0x63) returns registers from a fixed repeating list, one byte per eight serial clocks. By default the list is 0x02, 0x03, 0x04, 0x02, and so on.
- R7: One transaction is decoded per select-low period. After a single read or a burst, further serial clocks are not decoded until select has been raised.
- R8: The output enable is high only in the data phase of a read or burst. It is low during any address byte and during any write.
- R9: The output enable drops within one system cycle after the synchronised select is seen high.
- R10: The write strobe lasts exactly one system cycle and occurs only while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host (idles high) |
| sel_n_i | input | 1 | Active-low select from the host |
| dat_i | input | 1 | Data line as seen at the pad |
| dat_o | output | 1 | Value to drive onto the data line |
| dat_oe | output | 1 | Output enable for the data line pad |
| rd_addr | output | AW | Address presented to the register bank for reads |
| rd_data | input | DW | Register bank read data for rd_addr |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | AW | Write address, valid with wr_stb |
| wr_data | output | DW | Write data, valid with wr_stb |

## Verification
On every system cycle, the assertions check several properties. The output enable must be low while the synchronised select is high, and it must fall in the cycle after select is seen high. The write strobe must be a single cycle, must occur only while selected, and must never target a read-only address. While the port is driving, the driven bit may change only after a falling serial clock edge. Other behaviour can be shown only by the bench's scenarios, where a behavioural host and register model compare each transaction's outcome with the port. These behaviours are the framing of address and data bits, abort recovery, the burst list order and wrap, and frames ignored after a completed transaction.

// File: rtl/srp_pkg.sv
package srp_pkg;

   // Port sequencing states
   typedef enum logic [2:0] {
      ST_ADDR  = 3'd0,   // selected, collecting the command byte
      ST_WDATA = 3'd1,   // collecting the write data byte
      ST_RLOAD = 3'd2,   // fetching a register from the bank
      ST_RDATA = 3'd3,   // shifting a register out
      ST_DONE  = 3'd4    // transaction over, wait for deselect
   } srp_state_e;

   // Value of the command byte MSB that marks a write
   localparam logic DIR_WRITE = 1'b1;

endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
   parameter int               WIDTH     = 3,
   parameter int               STAGES    = 2,
   parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srp_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("srp_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RESET_VAL;
               else        chain[g] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[g] <= RESET_VAL;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/srp_edge.sv
module srp_edge #(
   parameter logic IDLE_LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic rise_o,
   output logic fall_o
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE_LEVEL;
      else        lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
   assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/srp_burst_seq.sv
module srp_burst_seq #(
   parameter int            AW   = 7,
   parameter logic [AW-1:0] BASE = 7'h02,
   parameter int            LEN  = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          step_i,
   output logic [AW-1:0] addr_o
);

   localparam int IW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(LEN - 1);

   generate
      if (LEN < 1) begin : g_bad_len
         $error("srp_burst_seq: LEN must be at least 1");
      end
      if (int'(BASE) + LEN > (1 << AW)) begin : g_bad_span
         $error("srp_burst_seq: burst list runs past the address space");
      end
   endgenerate

   generate
      if (LEN == 1) begin : g_single
         // One-entry list: the address never moves
         assign addr_o = BASE;
      end else begin : g_multi
         logic [IW-1:0] idx_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               idx_q <= '0;
            end else if (start_i) begin
               idx_q <= '0;
            end else if (step_i) begin
               idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
            end
         end

         assign addr_o = BASE + AW'(idx_q);
      end
   endgenerate

endmodule

// File: rtl/srp_ctrl.sv
module srp_ctrl
   import srp_pkg::*;
#(
   parameter int                   AW         = 7,
   parameter int                   DW         = 8,
   parameter logic [(1<<AW)-1:0]   RO_MAP     = '0,
   parameter logic [AW-1:0]        BURST_ADDR = 7'h63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n_s,
   input  logic          dat_s,
   input  logic          sck_rise,
   input  logic          sck_fall,
   output logic          burst_start,
   output logic          burst_step,
   input  logic [AW-1:0] burst_addr,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data,
   output logic          dat_o,
   output logic          dat_oe
);

   localparam int FW = ((AW + 1) > DW) ? (AW + 1) : DW;
   localparam int CW = $clog2(FW);
   localparam logic [CW-1:0] LAST_CMD = CW'(AW);
   localparam logic [CW-1:0] LAST_DAT = CW'(DW - 1);

   generate
      if (DW < 2) begin : g_bad_dw
         $error("srp_ctrl: DW must be at least 2");
      end
   endgenerate

   srp_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic [FW-1:0] in_sh_q;
   logic [FW-1:0] in_next;
   logic [DW-1:0] out_sh_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdat_q;
   logic          fresh_q;
   logic          burst_q;
   logic          oe_q;
   logic          dq_q;
   logic          stb_q;

   logic          cmd_done;
   logic          cmd_dir;
   logic [AW-1:0] cmd_addr;

   assign in_next  = {in_sh_q[FW-2:0], dat_s};
   assign cmd_dir  = in_next[AW];
   assign cmd_addr = in_next[AW-1:0];
   assign cmd_done = (state_q == ST_ADDR) && sck_rise && (cnt_q == LAST_CMD);

   // Burst list control, decoded from the same edges the state machine uses
   assign burst_start = cmd_done && (cmd_dir != DIR_WRITE) && (cmd_addr == BURST_ADDR);
   assign burst_step  = (state_q == ST_RDATA) && sck_rise && (cnt_q == LAST_DAT) && burst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_ADDR;
         cnt_q    <= '0;
         in_sh_q  <= '0;
         out_sh_q <= '0;
         addr_q   <= '0;
         wdat_q   <= '0;
         fresh_q  <= 1'b0;
         burst_q  <= 1'b0;
         oe_q     <= 1'b0;
         dq_q     <= 1'b0;
         stb_q    <= 1'b0;
      end else begin
         stb_q <= 1'b0;
         if (sel_n_s) begin
            // Deselected: drop everything, ready for a fresh command byte
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            fresh_q <= 1'b0;
            burst_q <= 1'b0;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_ADDR: begin
                  if (sck_rise) begin
                     in_sh_q <= in_next;
                     cnt_q   <= cnt_q + 1'b1;
                     if (cnt_q == LAST_CMD) begin
                        cnt_q  <= '0;
                        addr_q <= cmd_addr;
                        if (cmd_dir == DIR_WRITE) begin
                           state_q <= ST_WDATA;
                        end else begin
                           burst_q <= (cmd_addr == BURST_ADDR);
                           state_q <= ST_RLOAD;
                        end
                     end
                  end
               end
               ST_WDATA: begin
                  if (sck_rise) begin
                     in_sh_q <= in_next;
                     cnt_q   <= cnt_q + 1'b1;
                     if (cnt_q == LAST_DAT) begin
                        cnt_q   <= '0;
                        state_q <= ST_DONE;
                        if (!RO_MAP[addr_q]) begin
                           stb_q  <= 1'b1;
                           wdat_q <= in_next[DW-1:0];
                        end
                     end
                  end
               end
               ST_RLOAD: begin
                  out_sh_q <= rd_data;
                  fresh_q  <= 1'b1;
                  cnt_q    <= '0;
                  state_q  <= ST_RDATA;
               end
               ST_RDATA: begin
                  if (sck_fall) begin
                     if (fresh_q) begin
                        dq_q    <= out_sh_q[DW-1];
                        fresh_q <= 1'b0;
                        oe_q    <= 1'b1;
                     end else begin
                        dq_q     <= out_sh_q[DW-2];
                        out_sh_q <= {out_sh_q[DW-2:0], 1'b0};
                     end
                  end
                  if (sck_rise) begin
                     cnt_q <= cnt_q + 1'b1;
                     if (cnt_q == LAST_DAT) begin
                        cnt_q <= '0;
                        if (burst_q) begin
                           state_q <= ST_RLOAD;
                        end else begin
                           state_q <= ST_DONE;
                           oe_q    <= 1'b0;
                        end
                     end
                  end
               end
               ST_DONE: begin
                  state_q <= ST_DONE;
               end
               default: begin
                  state_q <= ST_DONE;
               end
            endcase
         end
      end
   end

   assign rd_addr = burst_q ? burst_addr : addr_q;
   assign wr_stb  = stb_q;
   assign wr_addr = addr_q;
   assign wr_data = wdat_q;
   assign dat_o   = dq_q;
   assign dat_oe  = oe_q;

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
   parameter int                 AW          = 7,
   parameter int                 DW          = 8,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [(1<<AW)-1:0] RO_MAP      = 128'hFF,
   parameter logic [AW-1:0]      BURST_ADDR  = 7'h63,
   parameter logic [AW-1:0]      BURST_BASE  = 7'h02,
   parameter int                 BURST_LEN   = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sck_i,
   input  logic          sel_n_i,
   input  logic          dat_i,
   output logic          dat_o,
   output logic          dat_oe,
   output logic [AW-1:0] rd_addr,
   input  logic [DW-1:0] rd_data,
   output logic          wr_stb,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data
);

   localparam int NSYNC = 3;
   // Bit order on the synchroniser bus: {select, clock, data}
   localparam logic [NSYNC-1:0] SYNC_RST = 3'b110;

   generate
      if (AW < 1 || AW > 10) begin : g_bad_aw
         $error("serial_reg_port: AW out of range");
      end
   endgenerate

   logic [NSYNC-1:0] pins_s;
   logic             sel_n_s;
   logic             sck_s;
   logic             dat_s;
   logic             sck_rise;
   logic             sck_fall;
   logic             burst_start;
   logic             burst_step;
   logic [AW-1:0]    burst_addr;

   srp_sync #(
      .WIDTH     (NSYNC),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (SYNC_RST)
   ) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({sel_n_i, sck_i, dat_i}),
      .sync_o  (pins_s)
   );

   assign sel_n_s = pins_s[2];
   assign sck_s   = pins_s[1];
   assign dat_s   = pins_s[0];

   srp_edge #(
      .IDLE_LEVEL (1'b1)
   ) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (sck_s),
      .rise_o (sck_rise),
      .fall_o (sck_fall)
   );

   srp_burst_seq #(
      .AW   (AW),
      .BASE (BURST_BASE),
      .LEN  (BURST_LEN)
   ) u_burst (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (burst_start),
      .step_i  (burst_step),
      .addr_o  (burst_addr)
   );

   srp_ctrl #(
      .AW         (AW),
      .DW         (DW),
      .RO_MAP     (RO_MAP),
      .BURST_ADDR (BURST_ADDR)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .sel_n_s     (sel_n_s),
      .dat_s       (dat_s),
      .sck_rise    (sck_rise),
      .sck_fall    (sck_fall),
      .burst_start (burst_start),
      .burst_step  (burst_step),
      .burst_addr  (burst_addr),
      .rd_addr     (rd_addr),
      .rd_data     (rd_data),
      .wr_stb      (wr_stb),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .dat_o       (dat_o),
      .dat_oe      (dat_oe)
   );

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
   parameter int                 AW     = 7,
   parameter logic [(1<<AW)-1:0] RO_MAP = '0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_n_s,
   input logic          sck_fall,
   input logic          dat_o,
   input logic          dat_oe,
   input logic          wr_stb,
   input logic [AW-1:0] wr_addr
);

   // R1: a port held deselected never drives
   p_quiet_desel_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n_s && $past(sel_n_s)) |-> !dat_oe);

   // R9: enable released in the cycle after select is seen high
   p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sel_n_s |=> !dat_oe);

   // R10: strobe is a single cycle
   p_stb_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   // R10: strobe only follows a selected cycle
   p_stb_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> $past(!sel_n_s));

   // R5: no strobe to a read-only address
   p_ro_no_stb_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> !RO_MAP[wr_addr]);

   // R3: while driving, the bit only moves after a falling serial edge
   p_dat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_oe && $past(dat_oe) && !$past(sck_fall)) |-> $stable(dat_o));

   // R8: no write strobe while the line is driven
   p_no_stb_driving_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dat_oe |-> !wr_stb);

endmodule

bind serial_reg_port srp_checker #(
   .AW     (AW),
   .RO_MAP (RO_MAP)
) u_srp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .sel_n_s  (sel_n_s),
   .sck_fall (sck_fall),
   .dat_o    (dat_o),
   .dat_oe   (dat_oe),
   .wr_stb   (wr_stb),
   .wr_addr  (wr_addr)
);

// File: tb/serial_reg_port_bench.sv
`timescale 1ns/1ps
module serial_reg_port_bench;

   localparam int HALF  = 6;      // serial clock half period in system cycles
   localparam int BADDR = 'h63;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b1;
   logic       sel_n = 1'b1;
   logic       host_d = 1'b0;
   logic       dat_o, dat_oe, wr_stb;
   logic [6:0] rd_addr, wr_addr;
   logic [7:0] rd_data, wr_data;
   logic       pad;

   logic [7:0] bank     [128];
   logic [7:0] exp_bank [128];

   int checks = 0, errors = 0;
   int stb_seen = 0, exp_stb = 0;
   int desel_cnt = 0;
   bit no_drive = 1'b0;
   bit prev_stb = 1'b0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   assign pad     = dat_oe ? dat_o : host_d;
   assign rd_data = bank[rd_addr];

   serial_reg_port u_serial_reg_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .sck_i   (sck),
      .sel_n_i (sel_n),
      .dat_i   (host_d),
      .dat_o   (dat_o),
      .dat_oe  (dat_oe),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Register bank model behind the port
   always @(posedge clk) begin
      if (wr_stb) begin
         bank[wr_addr] <= wr_data;
         stb_seen      <= stb_seen + 1;
      end
   end

   // Per-cycle comparison against the host-side model
   always @(negedge clk) begin
      if (rst_n) begin
         desel_cnt = sel_n ? desel_cnt + 1 : 0;
         if (desel_cnt >= 4) chk(!dat_oe && !wr_stb, "R1 idle port quiet", {dat_oe, wr_stb}, 0);
         if (no_drive) chk(!dat_oe, "R8 no drive outside read data", dat_oe, 0);
         if (wr_stb) chk(!prev_stb, "R10 strobe width", 2, 1);
         prev_stb = wr_stb;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input bit b);
      sck = 1'b0; host_d = b; cyc(HALF);
      sck = 1'b1; cyc(HALF);
   endtask

   task automatic read_bit(output bit b, input string req);
      sck = 1'b0; cyc(HALF);
      b = pad;
      chk(dat_oe == 1'b1, req, dat_oe, 1);
      sck = 1'b1; cyc(HALF);
   endtask

   task automatic send_byte(input logic [7:0] v, input int nbits);
      for (int i = 7; i > 7 - nbits; i--) send_bit(v[i]);
   endtask

   task automatic select_lo();
      sel_n = 1'b0; cyc(4);
   endtask

   task automatic select_hi();
      sel_n = 1'b1; host_d = 1'b0; cyc(10);
   endtask

   task automatic do_write(input int a, input logic [7:0] d);
      select_lo();
      no_drive = 1'b1;
      send_byte({1'b1, 7'(a)}, 8);
      send_byte(d, 8);
      no_drive = 1'b0;
      cyc(2);
      select_hi();
      if (a >= 8) begin
         exp_bank[a] = d;
         exp_stb++;
      end
   endtask

   task automatic read_byte(output logic [7:0] v, input string req);
      bit b;
      for (int i = 7; i >= 0; i--) begin
         read_bit(b, req);
         v[i] = b;
      end
   endtask

   task automatic do_read(input int a, output logic [7:0] v);
      select_lo();
      no_drive = 1'b1;
      send_byte({1'b0, 7'(a)}, 8);
      no_drive = 1'b0;
      read_byte(v, "R3 enable during read data");
      select_hi();
   endtask

   task automatic check_read(input int a, input string req);
      logic [7:0] v;
      do_read(a, v);
      chk(v == exp_bank[a], req, v, exp_bank[a]);
   endtask

   initial begin : main
      logic [7:0] v;
      for (int i = 0; i < 128; i++) begin
         bank[i]     = 8'(i * 37 + 11);
         exp_bank[i] = 8'(i * 37 + 11);
      end
      cyc(5);
      rst_n = 1'b1;
      cyc(5);

      // Reset state
      chk(dat_oe == 1'b0, "R1 reset enable", dat_oe, 0);
      chk(wr_stb == 1'b0, "R10 reset strobe", wr_stb, 0);

      // R1: a full write frame clocked while deselected has no effect
      no_drive = 1'b1;
      send_byte(8'hA0, 8);
      send_byte(8'h55, 8);
      no_drive = 1'b0;
      cyc(4);
      chk(stb_seen == exp_stb, "R1 no strobe when deselected", stb_seen, exp_stb);
      check_read('h20, "R1 register untouched");

      // R2: writes with several patterns, then read back
      do_write('h20, 8'hA5);
      chk(stb_seen == exp_stb, "R2 strobe count", stb_seen, exp_stb);
      do_write('h7F, 8'h3C);
      do_write('h10, 8'h00);
      do_write('h08, 8'hFF);
      chk(stb_seen == exp_stb, "R2 strobe count after four", stb_seen, exp_stb);
      check_read('h20, "R2 readback 0x20");
      check_read('h7F, "R2 readback 0x7F");
      check_read('h10, "R2 readback 0x10");
      check_read('h08, "R2 readback 0x08");

      // R3: reads of untouched and read-only registers
      check_read('h03, "R3 read 0x03");
      check_read('h55, "R3 read 0x55");

      // R5: write to a read-only address is dropped
      do_write('h05, 8'h5A);
      chk(stb_seen == exp_stb, "R5 no strobe for read-only", stb_seen, exp_stb);
      check_read('h05, "R5 read-only value kept");
      do_write('h00, 8'h11);
      chk(stb_seen == exp_stb, "R5 no strobe for address 0", stb_seen, exp_stb);

      // R4: abort a write after 12 bits
      select_lo();
      no_drive = 1'b1;
      send_byte(8'hB0, 8);
      send_byte(8'hC3, 4);
      no_drive = 1'b0;
      select_hi();
      chk(stb_seen == exp_stb, "R4 aborted write no strobe", stb_seen, exp_stb);
      check_read('h30, "R4 aborted target unchanged");

      // R4: abort one bit short of completion, then a clean write
      select_lo();
      no_drive = 1'b1;
      send_byte(8'hB1, 8);
      send_byte(8'h77, 7);
      no_drive = 1'b0;
      select_hi();
      chk(stb_seen == exp_stb, "R4 15-bit frame no strobe", stb_seen, exp_stb);
      do_write('h31, 8'h6E);
      check_read('h31, "R4 write after abort");

      // R9/R4: abort in the middle of a read data phase
      select_lo();
      no_drive = 1'b1;
      send_byte({1'b0, 7'h20}, 8);
      no_drive = 1'b0;
      begin
         bit b;
         for (int i = 0; i < 3; i++) read_bit(b, "R3 enable in partial read");
      end
      sel_n = 1'b1;
      cyc(5);
      chk(dat_oe == 1'b0, "R9 enable dropped after deselect", dat_oe, 0);
      cyc(5);
      check_read('h20, "R4 read after aborted read");

      // R6: burst returns 0x02,0x03,0x04 repeating
      select_lo();
      no_drive = 1'b1;
      send_byte({1'b0, 7'(BADDR)}, 8);
      no_drive = 1'b0;
      for (int k = 0; k < 7; k++) begin
         read_byte(v, "R6 enable during burst");
         chk(v == exp_bank[2 + (k % 3)], "R6 burst byte", v, exp_bank[2 + (k % 3)]);
      end
      select_hi();
      chk(dat_oe == 1'b0, "R7 burst ended by deselect", dat_oe, 0);
      check_read('h7F, "R7 normal read after burst");

      // R7: frame clocked after a completed read without deselect is ignored
      select_lo();
      no_drive = 1'b1;
      send_byte({1'b0, 7'h10}, 8);
      no_drive = 1'b0;
      read_byte(v, "R3 enable in read");
      chk(v == exp_bank['h10], "R3 read before trailing frame", v, exp_bank['h10]);
      no_drive = 1'b1;
      send_byte(8'hB2, 8);
      send_byte(8'h99, 8);
      no_drive = 1'b0;
      select_hi();
      chk(stb_seen == exp_stb, "R7 trailing write ignored", stb_seen, exp_stb);
      check_read('h32, "R7 trailing target unchanged");

      // R7: second frame in the same select after a write is ignored
      select_lo();
      no_drive = 1'b1;
      send_byte(8'hB3, 8);
      send_byte(8'h42, 8);
      send_byte(8'hB4, 8);
      send_byte(8'h24, 8);
      no_drive = 1'b0;
      select_hi();
      exp_bank['h33] = 8'h42;
      exp_stb++;
      chk(stb_seen == exp_stb, "R7 one write per select", stb_seen, exp_stb);
      check_read('h33, "R2 first frame committed");
      check_read('h34, "R7 second frame dropped");

      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule